// File: doc/BRIEF.md
# Registered Bidirectional Bus Transceiver

This block joins two parallel data buses, called A and B, and passes data between them without inversion. Each direction has its own holding register and its own capture strobe. A per-direction select chooses whether the far bus receives live data or the held register contents. A per-direction enable decides whether the block drives that bus at all. With these controls the block can pass data through in real time in either direction, store data from either bus or from both, replay stored data, or isolate the two buses completely.

Each bus appears as three port groups: the value arriving from outside, the value the block wants to drive, and a drive enable. The block resolves these into a pin value. The pin value is what the registers capture, even while the block itself drives that pin. So when live A data is driven onto B and both strobes rise together, one bus value lands in both registers.

The capture strobes are sampled on the system clock. A register loads at the first clock edge where its strobe is high after having been low at the previous edge. Live data is taken from the external input of the source bus. The driven value of the source bus is not used, so the two live paths cannot form a loop.

Top module: `bxr_transceiver`

## Requirements
- R1: While `rst_n` is low, both drive enables are low and both registers hold zero. Because the enables are low, each pin shows its external input.
- R2: The A-side register loads the resolved A pin at a clock edge where `clk_ab` is high and was low at the previous edge. It does not reload while `clk_ab` stays high, and it does not load when `clk_ab` falls.
- R3: The B-side register follows the same rule, using `clk_ba` and the resolved B pin.
- R4: Captures happen whatever the enables are. In isolation (`oe_ab`=0, `oe_ba_n`=1) neither bus is driven, and both registers can still be loaded.
- R5: `b_oe` equals `oe_ab`, which is active high. `a_oe` equals the inverse of `oe_ba_n`, which is active low.
- R6: With `sel_ab`=0, `b_out` equals `a_in` without inversion. With `sel_ab`=1, `b_out` equals the A-side register.
- R7: With `sel_ba`=0, `a_out` equals `b_in` without inversion. With `sel_ba`=1, `a_out` equals the B-side register.
- R8: Each pin equals the block's driven value when that bus's enable is high, and the external input otherwise.
- R9: Take `oe_ab`=1, `sel_ab`=0 and `oe_ba_n`=1, and let both strobes rise at the same edge. Both registers then receive `a_in`. The mirror case (`oe_ba_n`=0, `sel_ba`=0, `oe_ab`=0) loads `b_in` into both registers.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock; the strobes are sampled on its rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| clk_ab | input | 1 | Capture strobe for the A-side register |
| clk_ba | input | 1 | Capture strobe for the B-side register |
| oe_ab | input | 1 | Active-high enable for driving bus B |
| oe_ba_n | input | 1 | Active-low enable for driving bus A |
| sel_ab | input | 1 | Source for bus B: 0 live A, 1 stored A |
| sel_ba | input | 1 | Source for bus A: 0 live B, 1 stored B |
| a_in | input | W | Value arriving on bus A from outside |
| a_out | output | W | Value the block drives onto bus A |
| a_oe | output | 1 | Drive enable for bus A |
| a_pin | output | W | Resolved bus A value |
| b_in | input | W | Value arriving on bus B from outside |
| b_out | output | W | Value the block drives onto bus B |
| b_oe | output | 1 | Drive enable for bus B |
| b_pin | output | W | Resolved bus B value |

## Verification
The enables, the driven values and the pins are combinational. They are due in the same cycle as the inputs, so the bench checks them 1 time unit after driving new inputs on the falling clock edge. A capture takes effect at the rising edge that detects the strobe rise. The loaded register is first visible on `a_out` or `b_out`, in stored mode, at the next falling-edge check. The bench's reference model applies its own capture at that same rising edge, so every comparison sees register contents that are exactly one edge old.

// File: rtl/bxr_pkg.sv
package bxr_pkg;
    typedef enum logic {
        SRC_LIVE   = 1'b0,
        SRC_STORED = 1'b1
    } src_e;
endpackage

// File: rtl/bxr_rise_det.sv
module bxr_rise_det (
    input  logic clk,
    input  logic strobe,
    output logic rise
);
    logic prev_q;

    // Tracks the strobe on every edge, reset or not, so a rise is measured
    // against the level seen one edge earlier.
    always_ff @(posedge clk) begin
        prev_q <= strobe;
    end

    assign rise = strobe & ~prev_q;
endmodule

// File: rtl/bxr_path.sv
module bxr_path
    import bxr_pkg::*;
#(
    parameter int unsigned W = 8
) (
    input  src_e         sel,
    input  logic [W-1:0] live,
    input  logic [W-1:0] stored,
    output logic [W-1:0] dout
);
    always_comb begin
        unique case (sel)
            SRC_STORED: dout = stored;
            default:    dout = live;
        endcase
    end
endmodule

// File: rtl/bxr_pin.sv
module bxr_pin #(
    parameter int unsigned W = 8
) (
    input  logic         drv_en,
    input  logic [W-1:0] drv,
    input  logic [W-1:0] ext,
    output logic [W-1:0] pin
);
    assign pin = drv_en ? drv : ext;
endmodule

// File: rtl/bxr_transceiver.sv
module bxr_transceiver
    import bxr_pkg::*;
#(
    parameter int unsigned W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clk_ab,
    input  logic         clk_ba,
    input  logic         oe_ab,
    input  logic         oe_ba_n,
    input  logic         sel_ab,
    input  logic         sel_ba,
    input  logic [W-1:0] a_in,
    output logic [W-1:0] a_out,
    output logic         a_oe,
    output logic [W-1:0] a_pin,
    input  logic [W-1:0] b_in,
    output logic [W-1:0] b_out,
    output logic         b_oe,
    output logic [W-1:0] b_pin
);
    typedef struct packed {
        logic [W-1:0] a_reg;
        logic [W-1:0] b_reg;
    } state_t;

    state_t st_d, st_q;
    logic   rise_ab, rise_ba;

    bxr_rise_det u_rise_ab (.clk(clk), .strobe(clk_ab), .rise(rise_ab));
    bxr_rise_det u_rise_ba (.clk(clk), .strobe(clk_ba), .rise(rise_ba));

    // Drivers are held off whenever reset is low.
    assign b_oe = rst_n & oe_ab;
    assign a_oe = rst_n & ~oe_ba_n;

    // Live data comes from the source bus's external input, so the two
    // live paths can never feed each other.
    bxr_path #(.W(W)) u_path_ab (
        .sel(src_e'(sel_ab)), .live(a_in), .stored(st_q.a_reg), .dout(b_out)
    );
    bxr_path #(.W(W)) u_path_ba (
        .sel(src_e'(sel_ba)), .live(b_in), .stored(st_q.b_reg), .dout(a_out)
    );

    bxr_pin #(.W(W)) u_pin_a (.drv_en(a_oe), .drv(a_out), .ext(a_in), .pin(a_pin));
    bxr_pin #(.W(W)) u_pin_b (.drv_en(b_oe), .drv(b_out), .ext(b_in), .pin(b_pin));

    // Registers capture the resolved pins, whoever drives them.
    always_comb begin
        st_d = st_q;
        if (rise_ab) st_d.a_reg = a_pin;
        if (rise_ba) st_d.b_reg = b_pin;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end
endmodule

// File: rtl/bxr_chk.sv
module bxr_chk #(
    parameter int unsigned W = 8
) (
    input logic         clk,
    input logic         rst_n,
    input logic         clk_ab,
    input logic         clk_ba,
    input logic         oe_ab,
    input logic         oe_ba_n,
    input logic         sel_ab,
    input logic         sel_ba,
    input logic [W-1:0] a_out,
    input logic         a_oe,
    input logic [W-1:0] a_pin,
    input logic [W-1:0] b_out,
    input logic         b_oe,
    input logic [W-1:0] b_pin
);
    // R1
    reset_quiet_chk: assert property (@(posedge clk)
        !rst_n |-> (!a_oe && !b_oe));

    // R5
    b_enable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        b_oe == oe_ab);

    // R5
    a_enable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        a_oe == !oe_ba_n);

    // R2
    a_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(clk_ab) |=> (!sel_ab || b_out == $past(a_pin)));

    // R3
    b_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(clk_ba) |=> (!sel_ba || a_out == $past(b_pin)));
endmodule

bind bxr_transceiver bxr_chk #(.W(W)) u_chk (
    .clk(clk), .rst_n(rst_n), .clk_ab(clk_ab), .clk_ba(clk_ba),
    .oe_ab(oe_ab), .oe_ba_n(oe_ba_n), .sel_ab(sel_ab), .sel_ba(sel_ba),
    .a_out(a_out), .a_oe(a_oe), .a_pin(a_pin),
    .b_out(b_out), .b_oe(b_oe), .b_pin(b_pin)
);

// File: tb/sim_bxr_transceiver.sv
module sim_bxr_transceiver;
    localparam int  W          = 8;
    localparam time CLK_PERIOD = 10;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         clk_ab = 1'b0, clk_ba = 1'b0;
    logic         oe_ab = 1'b0, oe_ba_n = 1'b1, sel_ab = 1'b0, sel_ba = 1'b0;
    logic [W-1:0] a_in = '0, b_in = '0;
    logic [W-1:0] a_out, a_pin, b_out, b_pin;
    logic         a_oe, b_oe;

    int checks = 0;
    int errors = 0;

    // reference state
    logic [W-1:0] ra = '0, rb = '0;
    logic         pab = 1'b0, pba = 1'b0;

    bxr_transceiver #(.W(W)) u0 (
        .clk(clk), .rst_n(rst_n), .clk_ab(clk_ab), .clk_ba(clk_ba),
        .oe_ab(oe_ab), .oe_ba_n(oe_ba_n), .sel_ab(sel_ab), .sel_ba(sel_ba),
        .a_in(a_in), .a_out(a_out), .a_oe(a_oe), .a_pin(a_pin),
        .b_in(b_in), .b_out(b_out), .b_oe(b_oe), .b_pin(b_pin)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    function automatic logic [W-1:0] e_bout();
        return sel_ab ? ra : a_in;
    endfunction
    function automatic logic [W-1:0] e_aout();
        return sel_ba ? rb : b_in;
    endfunction
    function automatic logic e_aoe();
        return rst_n && !oe_ba_n;
    endfunction
    function automatic logic e_boe();
        return rst_n && oe_ab;
    endfunction
    function automatic logic [W-1:0] e_apin();
        return e_aoe() ? e_aout() : a_in;
    endfunction
    function automatic logic [W-1:0] e_bpin();
        return e_boe() ? e_bout() : b_in;
    endfunction

    // reference model: captures on a strobe rise seen at the clock edge
    always @(posedge clk) begin
        logic [W-1:0] na, nb;
        na = ra;
        nb = rb;
        if (!rst_n) begin
            na = '0;
            nb = '0;
        end else begin
            if (clk_ab && !pab) na = e_apin();
            if (clk_ba && !pba) nb = e_bpin();
        end
        ra  <= na;
        rb  <= nb;
        pab <= clk_ab;
        pba <= clk_ba;
    end

    task automatic check(input string req, input string what,
                         input logic [W-1:0] act, input logic [W-1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    task automatic compare_all();
        check(rst_n ? "R5" : "R1", "b_oe", W'(b_oe), W'(e_boe()));
        check(rst_n ? "R5" : "R1", "a_oe", W'(a_oe), W'(e_aoe()));
        check(sel_ab ? "R2" : "R6", "b_out", b_out, e_bout());
        check(sel_ba ? "R3" : "R7", "a_out", a_out, e_aout());
        check("R8", "a_pin", a_pin, e_apin());
        check("R8", "b_pin", b_pin, e_bpin());
    endtask

    task automatic apply(input logic [W-1:0] ai, input logic [W-1:0] bi,
                         input logic cab, input logic cba,
                         input logic oab, input logic oban,
                         input logic sab, input logic sba);
        @(negedge clk);
        a_in = ai; b_in = bi; clk_ab = cab; clk_ba = cba;
        oe_ab = oab; oe_ba_n = oban; sel_ab = sab; sel_ba = sba;
        #1;
        compare_all();
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        errors++;
        $display("FAIL watchdog expired: actual hung expected done");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        // R1: reset with enables requested and stored sources selected
        apply(8'hC3, 8'h4D, 1'b0, 1'b0, 1'b1, 1'b0, 1'b1, 1'b1);
        apply(8'hC3, 8'h4D, 1'b1, 1'b1, 1'b1, 1'b0, 1'b1, 1'b1);
        check("R1", "a_oe in reset", W'(a_oe), '0);
        check("R1", "b_oe in reset", W'(b_oe), '0);
        check("R1", "a_pin in reset", a_pin, 8'hC3);
        check("R1", "b_out reg in reset", b_out, '0);
        check("R1", "a_out reg in reset", a_out, '0);
        apply(8'h00, 8'h00, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0);
        @(negedge clk);
        rst_n = 1'b1;

        // R4: isolation, both registers loaded from the external inputs
        apply(8'h3C, 8'hA5, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0);
        apply(8'h3C, 8'hA5, 1'b1, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0);
        apply(8'h00, 8'h00, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 1'b1);
        check("R4", "stored A after isolation load", b_out, 8'h3C);
        check("R4", "stored B after isolation load", a_out, 8'hA5);
        check("R4", "no drive in isolation", W'({a_oe, b_oe}), '0);

        // R2: held-high strobe and falling strobe do not reload
        apply(8'h5A, 8'h00, 1'b1, 1'b0, 1'b0, 1'b1, 1'b1, 1'b1);
        apply(8'hFF, 8'h00, 1'b1, 1'b0, 1'b0, 1'b1, 1'b1, 1'b1);
        check("R2", "loaded on rise", b_out, 8'h5A);
        apply(8'hEE, 8'h00, 1'b1, 1'b0, 1'b0, 1'b1, 1'b1, 1'b1);
        apply(8'h01, 8'h00, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 1'b1);
        apply(8'h02, 8'h00, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 1'b1);
        check("R2", "held/fall ignored", b_out, 8'h5A);

        // R3: B-side capture of a driven B pin (stored A replayed onto B)
        apply(8'h00, 8'h77, 1'b0, 1'b1, 1'b1, 1'b1, 1'b1, 1'b1);
        apply(8'h00, 8'h77, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 1'b1);
        check("R3", "B reg took driven pin", a_out, 8'h5A);

        // R9: live A driven onto B, both strobes together
        apply(8'h96, 8'h00, 1'b1, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0);
        apply(8'h00, 8'h11, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 1'b1);
        check("R9", "A reg after shared load", b_out, 8'h96);
        check("R9", "B reg after shared load", a_out, 8'h96);

        // R9: mirror, live B driven onto A
        apply(8'h00, 8'h69, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0);
        apply(8'h22, 8'h00, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 1'b1);
        check("R9", "A reg after mirror load", b_out, 8'h69);
        check("R9", "B reg after mirror load", a_out, 8'h69);

        // R6 R7: live paths carry data unchanged
        apply(8'hA1, 8'h5E, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0);
        check("R6", "live A to B", b_pin, 8'hA1);
        check("R7", "live B to A", a_pin, 8'h5E);

        // mixed stimulus against the reference model
        for (int i = 0; i < 3000; i++) begin
            logic [31:0] r;
            r = $urandom;
            apply(W'($urandom), W'($urandom), r[0], r[1], r[2], r[3], r[4], r[5]);
        end

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule